// File: doc/BRIEF.md
# Halfword-Lane Calibration Pattern Engine

This block drives and verifies the fixed data pattern used while tuning memory read timing. On a start pulse its generator emits one 32-bit word per clock, with a word address running upward from zero, toward a memory write port. Each word comes from an 8-bit counter value: every counter bit either fills a whole 16-bit halfword with ones or leaves it at zero. Lanes therefore switch as full halfwords, which exposes skew between the two byte-pair lanes of the data path.

In check mode, read-back words arrive with their address. The checker rebuilds the expected word from the address and compares it with the data. It also confirms that addresses arrive in order. A check consists of two consecutive passes over the whole region. The first wrong word ends the check at once with a sticky fail result. A single-cycle done pulse closes every check. The pulse comes either after the first wrong word or after the last word of the final pass.

Top module: `calpat_engine`

## Requirements
- R1: After reset, wr_valid, chk_busy, chk_done and chk_fail are all 0.
- R2: The word for address w (10 bits) takes counter value i = w[9:2] and lane number k = w[1:0]. Bits [15:0] are 16'hFFFF when bit 2k of i is 1 and 0 otherwise. Bits [31:16] are 16'hFFFF when bit 2k+1 of i is 1 and 0 otherwise.
- R3: When the generator is idle, a gen_start pulse starts a stream in the next cycle. The stream holds wr_valid high for exactly 1024 consecutive cycles, with wr_index stepping 0,1,...,1023 and wr_data following R2. wr_valid is 0 afterwards.
- R4: A gen_start pulse while a stream is running is ignored: the stream continues unchanged to index 1023.
- R5: A check starts with chk_start. During the check, every cycle with rd_valid high takes one word. The word matches only if rd_index equals the position expected within the pass (0 upward) and rd_data equals the R2 word for rd_index.
- R6: A check needs two full passes of 1024 matching words. In the cycle after the last word of the second pass, chk_done is 1, chk_fail is 0 and chk_busy is 0. After the first pass the check stays busy with no done.
- R7: The first non-matching word, in either pass, ends the check. In the next cycle chk_done is 1, chk_fail is 1 and chk_busy is 0.
- R8: chk_fail holds its value until the next chk_start. chk_start clears chk_fail and sets chk_busy in the next cycle, and it restarts a check that is already in progress from position 0 of the first pass.
- R9: chk_done is high for exactly one cycle per check. rd_valid words presented while no check is busy have no effect on chk_done or chk_fail.
- R10: Cycles with rd_valid low do not advance the expected position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| gen_start | input | 1 | Start pulse for the write stream |
| wr_valid | output | 1 | Write word present |
| wr_index | output | 10 | Address of the write word |
| wr_data | output | 32 | Pattern word |
| chk_start | input | 1 | Start or restart a check |
| rd_valid | input | 1 | Read-back word present |
| rd_index | input | 10 | Address of the read-back word |
| rd_data | input | 32 | Read-back data |
| chk_busy | output | 1 | Check in progress |
| chk_done | output | 1 | One-cycle end-of-check pulse |
| chk_fail | output | 1 | Sticky result of the last check |

## Verification
The generator stream is compared word by word over all 1024 addresses, which covers every counter value and lane. The checker gets clean double passes with idle gaps mixed in; these show that a full run succeeds and that gaps do not advance the position. Single-bit corruptions are placed at the first word, the last word of the first pass and the last word of the second pass, which separates the end-of-pass boundaries from ordinary mismatches. An out-of-order address with correct data, a restart part-way through a check and words sent while idle show that ordering is enforced, that restart clears state and that idle input is ignored.

// File: rtl/calpat_pkg.sv
package calpat_pkg;
  typedef enum logic {
    CHK_IDLE = 1'b0,
    CHK_RUN  = 1'b1
  } chk_state_e;

  function automatic int addr_width(input int idx_w);
    return idx_w + $clog2(idx_w / 2);
  endfunction
endpackage

// File: rtl/calpat_word.sv
module calpat_word #(
  parameter int IDX_W = 8,
  parameter int HW_W  = 16,
  localparam int KW     = $clog2(IDX_W / 2),
  localparam int ADDR_W = IDX_W + KW
) (
  input  logic [ADDR_W-1:0] word_addr,
  output logic [2*HW_W-1:0] word
);
  logic [IDX_W-1:0] cnt_val;
  logic [KW-1:0]    lane_k;

  assign cnt_val = word_addr[ADDR_W-1 -: IDX_W];
  assign lane_k  = word_addr[KW-1:0];

  function automatic logic lane_bit(input logic [IDX_W-1:0] v,
                                    input logic [KW-1:0] k,
                                    input logic h);
    return v[{k, h}];
  endfunction

  for (genvar h = 0; h < 2; h++) begin : g_lane
    assign word[h*HW_W +: HW_W] = {HW_W{lane_bit(cnt_val, lane_k, 1'(h))}};
  end
endmodule

// File: rtl/calpat_gen.sv
module calpat_gen #(
  parameter int IDX_W = 8,
  parameter int HW_W  = 16,
  localparam int ADDR_W = calpat_pkg::addr_width(IDX_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              wr_valid,
  output logic [ADDR_W-1:0] wr_index,
  output logic [2*HW_W-1:0] wr_data
);
  localparam logic [ADDR_W-1:0] LAST = {ADDR_W{1'b1}};

  logic              run;
  logic [ADDR_W-1:0] cnt;
  logic              gen_last;

  assign gen_last = run && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run <= 1'b0;
      cnt <= '0;
    end else if (!run) begin
      if (start) run <= 1'b1;
      cnt <= '0;
    end else begin
      if (gen_last) run <= 1'b0;
      cnt <= cnt + 1'b1;
    end
  end

  calpat_word #(.IDX_W(IDX_W), .HW_W(HW_W)) i_word (
    .word_addr(cnt),
    .word     (wr_data)
  );

  assign wr_valid = run;
  assign wr_index = cnt;

  // R3: addresses step by one while streaming
  a_r3_stream_step: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !gen_last) |=> (run && cnt == $past(cnt) + 1'b1));
  // R3: stream stops after the last address
  a_r3_stream_stop: assert property (@(posedge clk) disable iff (!rst_n)
    gen_last |=> !run);
  // R3: a stream starts at address zero
  a_r3_stream_origin: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && start) |=> (run && cnt == '0));
endmodule

// File: rtl/calpat_chk.sv
module calpat_chk #(
  parameter int IDX_W      = 8,
  parameter int HW_W       = 16,
  parameter int CHK_PASSES = 2,
  localparam int ADDR_W = calpat_pkg::addr_width(IDX_W),
  localparam int PW     = (CHK_PASSES > 1) ? $clog2(CHK_PASSES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              rd_valid,
  input  logic [ADDR_W-1:0] rd_index,
  input  logic [2*HW_W-1:0] rd_data,
  output logic              busy,
  output logic              done,
  output logic              fail
);
  import calpat_pkg::*;

  localparam logic [ADDR_W-1:0] LAST      = {ADDR_W{1'b1}};
  localparam logic [PW-1:0]     LAST_PASS = PW'(CHK_PASSES - 1);

  chk_state_e        st;
  logic [ADDR_W-1:0] pos;
  logic [PW-1:0]     pass_cnt;
  logic [2*HW_W-1:0] expect_word;

  logic accept, word_ok, word_bad, pass_end, check_end;

  calpat_word #(.IDX_W(IDX_W), .HW_W(HW_W)) i_word (
    .word_addr(rd_index),
    .word     (expect_word)
  );

  assign accept    = (st == CHK_RUN) && rd_valid;
  assign word_ok   = (rd_index == pos) && (rd_data == expect_word);
  assign word_bad  = accept && !word_ok;
  assign pass_end  = accept && word_ok && (pos == LAST);
  assign check_end = pass_end && (pass_cnt == LAST_PASS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= CHK_IDLE;
      pos      <= '0;
      pass_cnt <= '0;
      done     <= 1'b0;
      fail     <= 1'b0;
    end else if (start) begin
      st       <= CHK_RUN;
      pos      <= '0;
      pass_cnt <= '0;
      done     <= 1'b0;
      fail     <= 1'b0;
    end else begin
      done <= 1'b0;
      if (word_bad) begin
        fail <= 1'b1;
        done <= 1'b1;
        st   <= CHK_IDLE;
      end else if (accept) begin
        pos <= pos + 1'b1;
        if (check_end) begin
          done <= 1'b1;
          st   <= CHK_IDLE;
        end else if (pass_end) begin
          pass_cnt <= pass_cnt + 1'b1;
        end
      end
    end
  end

  assign busy = (st == CHK_RUN);

  // R9: done lasts a single cycle
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R6/R7: a finished check is no longer busy
  a_r7_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  // R8: fail is sticky until the next start
  a_r8_fail_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (fail && !start) |=> fail);
  // R8: start clears fail and begins a check
  a_r8_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (busy && !fail && pos == '0));
  // R10: position holds across idle cycles
  a_r10_gap_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !rd_valid && !start) |=> $stable(pos));
  // R7: a bad word always ends in fail
  a_r7_bad_fails: assert property (@(posedge clk) disable iff (!rst_n)
    (word_bad && !start) |=> (fail && done));
endmodule

// File: rtl/calpat_engine.sv
module calpat_engine #(
  parameter int IDX_W      = 8,
  parameter int HW_W       = 16,
  parameter int CHK_PASSES = 2,
  localparam int ADDR_W = calpat_pkg::addr_width(IDX_W),
  localparam int DW     = 2 * HW_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              gen_start,
  output logic              wr_valid,
  output logic [ADDR_W-1:0] wr_index,
  output logic [DW-1:0]     wr_data,
  input  logic              chk_start,
  input  logic              rd_valid,
  input  logic [ADDR_W-1:0] rd_index,
  input  logic [DW-1:0]     rd_data,
  output logic              chk_busy,
  output logic              chk_done,
  output logic              chk_fail
);
  calpat_gen #(.IDX_W(IDX_W), .HW_W(HW_W)) i_gen (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (gen_start),
    .wr_valid(wr_valid),
    .wr_index(wr_index),
    .wr_data (wr_data)
  );

  calpat_chk #(.IDX_W(IDX_W), .HW_W(HW_W), .CHK_PASSES(CHK_PASSES)) i_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (chk_start),
    .rd_valid(rd_valid),
    .rd_index(rd_index),
    .rd_data (rd_data),
    .busy    (chk_busy),
    .done    (chk_done),
    .fail    (chk_fail)
  );

  // R1: outputs quiet while in reset
  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_n |=> (!wr_valid && !chk_busy && !chk_done && !chk_fail));
endmodule

// File: tb/test_calpat_engine.sv
`timescale 1ns/1ps
module test_calpat_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        gen_start = 1'b0;
  logic        wr_valid;
  logic [9:0]  wr_index;
  logic [31:0] wr_data;
  logic        chk_start = 1'b0;
  logic        rd_valid = 1'b0;
  logic [9:0]  rd_index = '0;
  logic [31:0] rd_data = '0;
  logic        chk_busy, chk_done, chk_fail;

  int n_cmp = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  calpat_engine i_calpat_engine (
    .clk(clk), .rst_n(rst_n), .gen_start(gen_start),
    .wr_valid(wr_valid), .wr_index(wr_index), .wr_data(wr_data),
    .chk_start(chk_start), .rd_valid(rd_valid), .rd_index(rd_index),
    .rd_data(rd_data), .chk_busy(chk_busy), .chk_done(chk_done),
    .chk_fail(chk_fail)
  );

  function automatic logic [31:0] model_word(input int w);
    int i = w / 4;
    int k = w % 4;
    logic [31:0] r = 0;
    if (((i >> (2 * k)) % 2) == 1) r = r + 32'h0000_FFFF;
    if (((i >> (2 * k + 1)) % 2) == 1) r = r + 32'hFFFF_0000;
    return r;
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic chk_status(input string req, input logic b,
                            input logic d, input logic f);
    check(req, "busy", 32'(chk_busy), 32'(b));
    check(req, "done", 32'(chk_done), 32'(d));
    check(req, "fail", 32'(chk_fail), 32'(f));
  endtask

  task automatic begin_check();
    @(negedge clk);
    rd_valid = 1'b0;
    chk_start = 1'b1;
    @(negedge clk);
    chk_start = 1'b0;
    chk_status("R8", 1'b1, 1'b0, 1'b0);
  endtask

  task automatic send(input int idx, input logic [31:0] data);
    @(negedge clk);
    rd_valid = 1'b1;
    rd_index = idx[9:0];
    rd_data  = data;
  endtask

  task automatic quiet();
    @(negedge clk);
    rd_valid = 1'b0;
  endtask

  // Feeds a check; the word at absolute position bad_at (pass*1024+w)
  // gets bit flip; -1 means clean. Gaps every gap_every words (0: none).
  task automatic run_check(input int bad_at, input int gap_every, input string req);
    begin_check();
    for (int p = 0; p < 2048; p++) begin
      logic [31:0] d = model_word(p % 1024);
      if (p == bad_at) d = d ^ 32'h0001_0000;
      if (gap_every != 0 && p % gap_every == gap_every - 1) begin
        quiet();
        quiet();
      end
      send(p % 1024, d);
      if (p == bad_at) begin
        quiet();
        chk_status(req, 1'b0, 1'b1, 1'b1);
        quiet();
        chk_status("R9", 1'b0, 1'b0, 1'b1);
        return;
      end
      if (p == 1023) begin
        quiet();
        chk_status("R6", 1'b1, 1'b0, 1'b0);
      end
    end
    quiet();
    chk_status(req, 1'b0, 1'b1, 1'b0);
    quiet();
    chk_status("R9", 1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    #1_000_000;
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", "wr_valid", 32'(wr_valid), 32'd0);
    chk_status("R1", 1'b0, 1'b0, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "wr_valid idle", 32'(wr_valid), 32'd0);

    // R2/R3/R4 full generator sweep with a stray start mid-stream
    gen_start = 1'b1;
    @(negedge clk);
    gen_start = 1'b0;
    for (int w = 0; w < 1024; w++) begin
      check("R3", "wr_valid", 32'(wr_valid), 32'd1);
      check("R3", "wr_index", 32'(wr_index), 32'(w));
      check("R2", "wr_data", wr_data, model_word(w));
      gen_start = (w == 300);
      @(negedge clk);
    end
    gen_start = 1'b0;
    check("R4", "wr_valid after end", 32'(wr_valid), 32'd0);
    @(negedge clk);
    check("R3", "wr_valid stays low", 32'(wr_valid), 32'd0);

    // R6/R10 clean double pass, with and without gaps
    run_check(-1, 0, "R6");
    run_check(-1, 97, "R10");

    // R5/R7 single corruptions at boundaries
    run_check(0, 0, "R5");
    run_check(1023, 0, "R7");
    run_check(2047, 0, "R7");
    run_check(1024 + 511, 13, "R7");

    // R8 fail sticky, R9 idle words ignored
    repeat (4) @(negedge clk);
    chk_status("R8", 1'b0, 1'b0, 1'b1);
    send(5, 32'h1234_5678);
    send(0, model_word(0));
    quiet();
    chk_status("R9", 1'b0, 1'b0, 1'b1);

    // R5 out-of-order address with correct data
    begin_check();
    send(0, model_word(0));
    send(2, model_word(2));
    quiet();
    chk_status("R5", 1'b0, 1'b1, 1'b1);

    // R8 restart in the middle of a clean check, then clean finish
    begin_check();
    for (int w = 0; w < 600; w++) send(w, model_word(w));
    quiet();
    chk_status("R8", 1'b1, 1'b0, 1'b0);
    run_check(-1, 0, "R8");

    repeat (2) @(negedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule